// File: doc/BRIEF.md
# VLIW Packet Issue Sequencer

The sequencer walks through the instructions of one VLIW packet, one slot at a time. A packet starts at a given address. For each slot the sequencer fetches a 32-bit word, clears general register 0, and hands the instruction to execution. It then waits for execution to return the address of the next instruction and the unit that ran the slot. A packet ends when the fetched word carries the end marker in its top bit, or when the slot limit is reached.

When the packet is over, the sequencer sends out a single pulse. That pulse tells the surrounding core to commit its deferred writes and to check for interrupts. The retired-instruction total then grows by the number of slots issued. While the packet runs, the sequencer keeps the program counter up to date after every slot, so that an interrupt always sees the right address. It also records which of the four media units was the last one used in the packet.

Decode and the execution units live outside this block. Fetch, dispatch and completion reach them through valid/ready style ports.

Top module: `vliw_issue_seq`

## Requirements
- R1: After reset the block is idle: start_ready is 1, fetch_valid, gr0_we, disp_valid and pkt_done are 0, retired is 0 and media_valid is 0.
- R2: Each slot fetches exactly one word at fetch_addr, which equals the current program counter. A fetched word with bit 31 set is the last slot of its packet (disp_last = 1).
- R3: A packet never issues more than MAX_SLOTS slots (default 4). The slot with index MAX_SLOTS-1 is dispatched with disp_last = 1, whatever its bit 31 holds.
- R4: gr0_we is high for exactly one cycle before each dispatch, and disp_valid first rises in the cycle right after that pulse.
- R5: disp_first is 1 for the first slot of a packet and 0 for every later slot.
- R6: When a slot completes, the program counter takes exec_next_pc. That value appears on cur_pc and is used as the next fetch address, including for non-sequential targets.
- R7: A completed slot whose exec_unit lies in MEDIA_BASE..MEDIA_BASE+3 (default 8..11) sets media_valid = 1 and media_idx = exec_unit - MEDIA_BASE. A unit outside that range leaves the record unchanged. Accepting a new packet clears media_valid.
- R8: After the last slot completes, pkt_done pulses for one cycle. In the following cycle retired grows by the number of slots in the packet, and at no other time.
- R9: start_ready is 1 only while idle. No new packet is accepted until the current one has pulsed pkt_done.
- R10: While disp_valid is 1 and disp_ready is 0, disp_valid, disp_pc and disp_word hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request to begin a packet |
| start_pc | input | AW | Address of the packet's first word |
| start_ready | output | 1 | Sequencer is idle and accepts a packet |
| fetch_valid | output | 1 | Fetch request |
| fetch_addr | output | AW | Address to fetch |
| fetch_ready | input | 1 | Fetch word is returned this cycle |
| fetch_word | input | 32 | Fetched instruction word |
| gr0_we | output | 1 | Write zero to general register 0 |
| disp_valid | output | 1 | Instruction offered to execution |
| disp_ready | input | 1 | Execution accepts the instruction |
| disp_pc | output | AW | Address of the dispatched instruction |
| disp_word | output | 32 | Dispatched instruction word |
| disp_first | output | 1 | First slot of the packet |
| disp_last | output | 1 | Last slot of the packet |
| exec_done | input | 1 | Dispatched instruction completed |
| exec_next_pc | input | AW | Address of the next instruction |
| exec_unit | input | UNIT_W | Unit that executed the slot |
| cur_pc | output | AW | Current program counter |
| media_valid | output | 1 | A media unit has been used in this packet |
| media_idx | output | 2 | Index of the last media unit used |
| pkt_done | output | 1 | Packet finished: commit deferred writes and check interrupts |
| retired | output | CNT_W | Retired-instruction total |

## Verification
The checker watches several properties on every cycle:
- the one-cycle register-0 clear that comes before each dispatch;
- the dispatch holding still under back-pressure;
- the single-cycle completion pulse;
- the retired total changing only after that pulse;
- the media record clearing when a packet is accepted;
- start_ready staying low while a packet is running.

Other behaviours need the bench's reference model and chosen packets to show them:
- the end marker in bit 31;
- the cap at MAX_SLOTS;
- a taken branch in the middle of a packet;
- a media record that survives a later non-media slot;
- the exact amount added to the retired total.

// File: rtl/vliw_seq_pkg.sv
package vliw_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CLEAR,
        ST_DISP,
        ST_WAIT,
        ST_FINISH
    } seq_state_e;

    typedef struct packed {
        logic       vld;
        logic [1:0] idx;
    } media_rec_t;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned END_BIT  = 31;
    localparam int unsigned N_MEDIA  = 4;

endpackage

// File: rtl/vseq_end_detect.sv
module vseq_end_detect
    import vliw_seq_pkg::*;
#(
    parameter int unsigned MAX_SLOTS = 4,
    parameter int unsigned SW        = 3
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SW-1:0]     slot_idx,
    output logic              is_last
);
    localparam logic [SW-1:0] LAST_IDX = SW'(MAX_SLOTS - 1);

    always_comb begin
        is_last = word[END_BIT] || (slot_idx >= LAST_IDX);
    end
endmodule

// File: rtl/vseq_media_track.sv
module vseq_media_track
    import vliw_seq_pkg::*;
#(
    parameter int unsigned UNIT_W     = 4,
    parameter int unsigned MEDIA_BASE = 8
) (
    input  media_rec_t        cur,
    input  logic              clear,
    input  logic              update,
    input  logic [UNIT_W-1:0] unit,
    output media_rec_t        nxt
);
    logic [N_MEDIA-1:0] hit;

    for (genvar g = 0; g < N_MEDIA; g++) begin : g_match
        assign hit[g] = (unit == UNIT_W'(MEDIA_BASE + g));
    end

    always_comb begin
        nxt = cur;
        if (clear) begin
            nxt = '0;
        end else if (update && (hit != '0)) begin
            nxt.vld = 1'b1;
            for (int i = 0; i < N_MEDIA; i++) begin
                if (hit[i]) nxt.idx = 2'(i);
            end
        end
    end
endmodule

// File: rtl/vseq_retire_ctr.sv
module vseq_retire_ctr #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned SW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [SW-1:0]    add_val,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] total_d, total_q;

    always_comb begin
        total_d = total_q;
        if (add_en) total_d = total_q + CNT_W'(add_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) total_q <= '0;
        else        total_q <= total_d;
    end

    assign total = total_q;
endmodule

// File: rtl/vliw_issue_seq.sv
module vliw_issue_seq
    import vliw_seq_pkg::*;
#(
    parameter int unsigned AW         = 32,
    parameter int unsigned MAX_SLOTS  = 4,
    parameter int unsigned UNIT_W     = 4,
    parameter int unsigned MEDIA_BASE = 8,
    parameter int unsigned CNT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [AW-1:0]     start_pc,
    output logic              start_ready,
    output logic              fetch_valid,
    output logic [AW-1:0]     fetch_addr,
    input  logic              fetch_ready,
    input  logic [31:0]       fetch_word,
    output logic              gr0_we,
    output logic              disp_valid,
    input  logic              disp_ready,
    output logic [AW-1:0]     disp_pc,
    output logic [31:0]       disp_word,
    output logic              disp_first,
    output logic              disp_last,
    input  logic              exec_done,
    input  logic [AW-1:0]     exec_next_pc,
    input  logic [UNIT_W-1:0] exec_unit,
    output logic [AW-1:0]     cur_pc,
    output logic              media_valid,
    output logic [1:0]        media_idx,
    output logic              pkt_done,
    output logic [CNT_W-1:0]  retired
);
    localparam int unsigned SW = $clog2(MAX_SLOTS + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [AW-1:0]   pc;
        logic [31:0]     word;
        logic [SW-1:0]   slot;
        logic            first;
        media_rec_t      media;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic       last_slot;
    logic       start_hs;
    logic       done_hs;
    media_rec_t media_nxt;

    vseq_end_detect #(.MAX_SLOTS(MAX_SLOTS), .SW(SW)) i_end (
        .word     (r_q.word),
        .slot_idx (r_q.slot),
        .is_last  (last_slot)
    );

    vseq_media_track #(.UNIT_W(UNIT_W), .MEDIA_BASE(MEDIA_BASE)) i_media (
        .cur    (r_q.media),
        .clear  (start_hs),
        .update (done_hs),
        .unit   (exec_unit),
        .nxt    (media_nxt)
    );

    vseq_retire_ctr #(.CNT_W(CNT_W), .SW(SW)) i_ret (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (r_q.st == ST_FINISH),
        .add_val (r_q.slot),
        .total   (retired)
    );

    assign start_hs = (r_q.st == ST_IDLE) && start_valid;
    assign done_hs  = (r_q.st == ST_WAIT) && exec_done;

    always_comb begin
        r_d       = r_q;
        r_d.media = media_nxt;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_valid) begin
                    r_d.pc    = start_pc;
                    r_d.slot  = '0;
                    r_d.first = 1'b1;
                    r_d.st    = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (fetch_ready) begin
                    r_d.word = fetch_word;
                    r_d.st   = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                r_d.st = ST_DISP;
            end
            ST_DISP: begin
                if (disp_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (exec_done) begin
                    r_d.pc    = exec_next_pc;
                    r_d.slot  = r_q.slot + 1'b1;
                    r_d.first = 1'b0;
                    r_d.st    = last_slot ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FINISH: begin
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, pc: '0, word: '0, slot: '0,
                     first: 1'b0, media: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign start_ready = (r_q.st == ST_IDLE);
    assign fetch_valid = (r_q.st == ST_FETCH);
    assign fetch_addr  = r_q.pc;
    assign gr0_we      = (r_q.st == ST_CLEAR);
    assign disp_valid  = (r_q.st == ST_DISP);
    assign disp_pc     = r_q.pc;
    assign disp_word   = r_q.word;
    assign disp_first  = r_q.first;
    assign disp_last   = last_slot;
    assign cur_pc      = r_q.pc;
    assign media_valid = r_q.media.vld;
    assign media_idx   = r_q.media.idx;
    assign pkt_done    = (r_q.st == ST_FINISH);
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_valid,
    input logic             start_ready,
    input logic             fetch_valid,
    input logic             gr0_we,
    input logic             disp_valid,
    input logic             disp_ready,
    input logic [AW-1:0]    disp_pc,
    input logic [31:0]      disp_word,
    input logic             media_valid,
    input logic             pkt_done,
    input logic [CNT_W-1:0] retired
);
    p_gr0_before_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_valid) |-> $past(gr0_we));

    p_gr0_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        gr0_we |=> !gr0_we && disp_valid);

    p_disp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid && !disp_ready |=> disp_valid && $stable(disp_pc) && $stable(disp_word));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    p_retire_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_done |=> $stable(retired));

    p_media_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && start_ready |=> !media_valid);

    p_busy_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid || disp_valid || gr0_we) |-> !start_ready);
endmodule

bind vliw_issue_seq vseq_checker #(.AW(AW), .CNT_W(CNT_W)) i_vseq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .fetch_valid (fetch_valid),
    .gr0_we      (gr0_we),
    .disp_valid  (disp_valid),
    .disp_ready  (disp_ready),
    .disp_pc     (disp_pc),
    .disp_word   (disp_word),
    .media_valid (media_valid),
    .pkt_done    (pkt_done),
    .retired     (retired)
);

// File: tb/test_vliw_issue_seq.sv
module test_vliw_issue_seq;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS = 4;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        start_valid = 0;
    logic [31:0] start_pc = 0;
    logic        start_ready;
    logic        fetch_valid;
    logic [31:0] fetch_addr;
    logic        fetch_ready = 0;
    logic [31:0] fetch_word = 0;
    logic        gr0_we;
    logic        disp_valid;
    logic        disp_ready = 0;
    logic [31:0] disp_pc;
    logic [31:0] disp_word;
    logic        disp_first;
    logic        disp_last;
    logic        exec_done = 0;
    logic [31:0] exec_next_pc = 0;
    logic [3:0]  exec_unit = 0;
    logic [31:0] cur_pc;
    logic        media_valid;
    logic [1:0]  media_idx;
    logic        pkt_done;
    logic [31:0] retired;

    vliw_issue_seq i_vliw_issue_seq (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_pc(start_pc), .start_ready(start_ready),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_word(fetch_word),
        .gr0_we(gr0_we),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_pc(disp_pc),
        .disp_word(disp_word), .disp_first(disp_first), .disp_last(disp_last),
        .exec_done(exec_done), .exec_next_pc(exec_next_pc), .exec_unit(exec_unit),
        .cur_pc(cur_pc), .media_valid(media_valid), .media_idx(media_idx),
        .pkt_done(pkt_done), .retired(retired)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem   [int unsigned];
    int          umap  [int unsigned];
    logic [31:0] brmap [int unsigned];

    int unsigned q_pc[$], q_word[$];
    bit          q_first[$], q_last[$];
    int unsigned p_pc[$];
    bit          p_mv[$];
    int          p_mi[$];
    int          p_ret[$];

    int  exp_retired = 0;
    int  chk_ret_val = 0;
    bit  chk_ret = 0;
    bit  busy = 0;
    bit  req_go = 0;
    int unsigned req_pc = 0;
    int  done_cnt = 0;
    int  cyc = 0;
    int  pend = 0;
    int unsigned pend_pc = 0;
    int  nslots_seen = 0;
    bit  gr0_seen = 0;
    bit  held = 0;
    int unsigned held_pc = 0, held_word = 0;
    bit  in_reset = 1;

    function automatic logic [31:0] mem_rd(int unsigned a);
        if (mem.exists(a)) return mem[a];
        return {1'b0, a[30:0]};
    endfunction

    function automatic logic [31:0] next_of(int unsigned a);
        if (brmap.exists(a)) return brmap[a];
        return a + 4;
    endfunction

    function automatic int unit_of(int unsigned a);
        if (umap.exists(a)) return umap[a];
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference model: computes the expected slot sequence of one packet.
    task automatic model_packet(int unsigned pc0);
        int unsigned pc = pc0;
        bit mv = 0;
        int mi = 0;
        int n = 0;
        for (int s = 0; s < MAXS; s++) begin
            logic [31:0] w = mem_rd(pc);
            bit lst = w[31] || (s == MAXS-1);
            int u = unit_of(pc);
            q_pc.push_back(pc);
            q_word.push_back(w);
            q_first.push_back(s == 0);
            q_last.push_back(lst);
            if (u >= 8 && u <= 11) begin mv = 1; mi = u - 8; end
            pc = next_of(pc);
            n++;
            if (lst) break;
        end
        exp_retired += n;
        p_pc.push_back(pc);
        p_mv.push_back(mv);
        p_mi.push_back(mi);
        p_ret.push_back(exp_retired);
    endtask

    always @(negedge clk) begin
        bit hs;
        cyc++;
        if (!in_reset) begin
            // R9: start_ready mirrors idle
            check(start_ready == !busy, "R9", "start_ready", start_ready, !busy);

            if (chk_ret) begin
                check(retired == chk_ret_val, "R8", "retired", retired, chk_ret_val);
                chk_ret = 0;
            end

            // R10: held dispatch
            if (held) begin
                check(disp_valid && disp_pc == held_pc && disp_word == held_word,
                      "R10", "held disp_pc", disp_pc, held_pc);
                held = 0;
            end

            if (gr0_we) gr0_seen = 1;

            // fetch side, R2
            if (fetch_valid) begin
                if (q_pc.size() > 0)
                    check(fetch_addr == q_pc[0], "R2", "fetch_addr", fetch_addr, q_pc[0]);
                fetch_ready = (cyc % 4) != 1;
                fetch_word  = mem_rd(fetch_addr);
            end else begin
                fetch_ready = 0;
            end

            // dispatch side
            disp_ready = (cyc % 3) != 0;
            hs = disp_valid && disp_ready;
            if (disp_valid && !disp_ready) begin
                held = 1; held_pc = disp_pc; held_word = disp_word;
            end
            if (hs) begin
                check(gr0_seen, "R4", "gr0 clear before dispatch", gr0_seen, 1);
                gr0_seen = 0;
                if (q_pc.size() == 0) begin
                    check(0, "R2", "unexpected dispatch", disp_pc, 0);
                end else begin
                    check(disp_pc == q_pc[0], "R6", "disp_pc", disp_pc, q_pc[0]);
                    check(disp_word == q_word[0], "R2", "disp_word", disp_word, q_word[0]);
                    check(disp_first == q_first[0], "R5", "disp_first", disp_first, q_first[0]);
                    check(disp_last == q_last[0], "R3", "disp_last", disp_last, q_last[0]);
                    void'(q_pc.pop_front()); void'(q_word.pop_front());
                    void'(q_first.pop_front()); void'(q_last.pop_front());
                end
                pend = 1 + (nslots_seen % 2);
                pend_pc = disp_pc;
                nslots_seen++;
            end

            // execution completion
            exec_done = 0;
            if (pend > 0 && !hs) begin
                pend--;
                if (pend == 0) begin
                    exec_done    = 1;
                    exec_next_pc = next_of(pend_pc);
                    exec_unit    = 4'(unit_of(pend_pc));
                end
            end

            // packet completion, R8 R7 R6
            if (pkt_done) begin
                if (p_pc.size() == 0) begin
                    check(0, "R8", "unexpected pkt_done", 1, 0);
                end else begin
                    check(q_pc.size() == 0, "R3", "slots left at done", q_pc.size(), 0);
                    check(cur_pc == p_pc[0], "R6", "final pc", cur_pc, p_pc[0]);
                    check(media_valid == p_mv[0], "R7", "media_valid", media_valid, p_mv[0]);
                    if (p_mv[0])
                        check(media_idx == 2'(p_mi[0]), "R7", "media_idx", media_idx, p_mi[0]);
                    chk_ret_val = p_ret[0];
                    chk_ret = 1;
                    void'(p_pc.pop_front()); void'(p_mv.pop_front());
                    void'(p_mi.pop_front()); void'(p_ret.pop_front());
                end
                busy = 0;
                done_cnt++;
            end

            // start driver
            start_valid = 0;
            if (req_go && start_ready && !busy) begin
                start_valid = 1;
                start_pc    = req_pc;
                busy        = 1;
                req_go      = 0;
            end
        end
        if (cyc > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic run_packet(int unsigned pc0);
        int target;
        model_packet(pc0);
        target = done_cnt + 1;
        req_pc = pc0;
        req_go = 1;
        while (done_cnt < target) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check(start_ready == 1 && fetch_valid == 0 && gr0_we == 0 && disp_valid == 0
              && pkt_done == 0, "R1", "idle outputs", {start_ready, fetch_valid, disp_valid}, 3'b100);
        check(retired == 0, "R1", "retired", retired, 0);
        check(media_valid == 0, "R1", "media_valid", media_valid, 0);
        in_reset = 0;

        // R2 R7: two slots, end marker on second, media unit 9
        mem[32'h104] = 32'h8000_0104;
        umap[32'h104] = 9;
        run_packet(32'h100);

        // R3 R7: no end marker, cap at MAXS; media 8 then 11 then non-media
        umap[32'h200] = 8; umap[32'h204] = 11; umap[32'h208] = 3;
        run_packet(32'h200);

        // R7: single slot with non-media unit clears record at start
        mem[32'h300] = 32'h8000_0300;
        umap[32'h300] = 2;
        run_packet(32'h300);

        // R6: taken branch inside packet
        brmap[32'h400] = 32'h800;
        mem[32'h800] = 32'h8000_0abc;
        umap[32'h800] = 10;
        run_packet(32'h400);

        // R9: back-to-back packets
        mem[32'h500] = 32'h8123_4567;
        run_packet(32'h500);

        repeat (5) @(posedge clk);
        check(retired == 32'(exp_retired), "R8", "final retired", retired, exp_retired);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule